// File: doc/BRIEF.md
# Memory Sleep Sequencer

This block wraps a small synchronous storage array and governs its passage into and out of a low-power sleep state. A single active-high request input, already synchronised to the clock, starts a fixed two-cycle entry phase. When that phase completes, the array is asleep. While asleep, every command input except the request is disregarded and the read data output is not driven. When the request falls, a recovery window of a parameterised number of cycles follows. In that window reads are served and writes are discarded. Normal operation then resumes.

Sleep never touches the array contents. The current phase is reported on a two-bit state output. Two flags show when inputs are being ignored and when writes are being discarded. The recovery length is computed at elaboration time from a recovery time and a clock period, both given in picoseconds, with the quotient rounded up.

Top module: `sleep_seq_top`

## Requirements
- R1: After reset, state_o is 2'b00 (active), rdata_oe_o is 0, in_block_o is 0 and wr_block_o is 0.
- R2: A high sleep_req_i sampled in the active state moves state_o to 2'b01 (entering) after that edge. If the request stays high, state_o becomes 2'b10 (asleep) after the second following edge.
- R3: A low sleep_req_i sampled while entering returns state_o to 2'b00 after that edge, without passing through the asleep state.
- R4: Commands sampled while entering are served exactly as in the active state.
- R5: While asleep, in_block_o is 1, rdata_oe_o is 0, and commands sampled in that state change neither the stored data nor the outputs.
- R6: A low sleep_req_i sampled while asleep moves state_o to 2'b11 (recovering) for REC_CYC cycles, then to 2'b00. REC_CYC = ceil(RECOVERY_PS / CLK_PERIOD_PS), with a minimum of 1.
- R7: While recovering, wr_block_o is 1, writes are discarded, and reads are served.
- R8: Data written before a sleep is read back unchanged after it.
- R9: A read (sel_i=1, we_i=0) sampled at an edge puts the addressed word on rdata_o with rdata_oe_o=1 for the following cycle. A write (sel_i=1, we_i=1) stores wdata_i at addr_i. With sel_i=0, or with a write, rdata_oe_o is 0 in the following cycle.
- R10: A high sleep_req_i sampled while recovering moves state_o back to 2'b01 and restarts the two-cycle entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_req_i | input | 1 | Synchronised sleep request, active high |
| sel_i | input | 1 | Command select |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data |
| rdata_oe_o | output | 1 | Read data drive enable (0 = high impedance) |
| state_o | output | 2 | 00 active, 01 entering, 10 asleep, 11 recovering |
| in_block_o | output | 1 | Command inputs are ignored |
| wr_block_o | output | 1 | Writes are discarded |

## Verification
The hardest case to reach from the ports is a request that changes while the block is between phases. Two such cases are a drop on the second entry cycle and a re-request inside the short recovery window; each needs the request edge placed on one exact clock. Directed sequences place both edges deliberately. A seeded random phase then holds the request in runs of random length while commands of both kinds keep arriving, which exposes the reads issued on the final entry cycle that must stay masked.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;
  typedef enum logic [1:0] {
    SLP_ACTIVE  = 2'b00,
    SLP_ENTER   = 2'b01,
    SLP_ASLEEP  = 2'b10,
    SLP_RECOVER = 2'b11
  } slp_state_e;

  localparam int unsigned ENTRY_CYCLES = 2;

  function automatic int unsigned ceil_div(int unsigned num, int unsigned den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/sleep_seq_fsm.sv
module sleep_seq_fsm
  import sleep_seq_pkg::*;
#(
  parameter int unsigned REC_CYC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_req_i,
  output slp_state_e state_o
);
  localparam int unsigned CNT_MAX = (REC_CYC > ENTRY_CYCLES) ? REC_CYC : ENTRY_CYCLES;
  localparam int unsigned CNT_W   = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX);

  slp_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      SLP_ACTIVE: if (sleep_req_i) begin
        state_d = SLP_ENTER;
        cnt_d   = '0;
      end
      SLP_ENTER: begin
        if (!sleep_req_i) state_d = SLP_ACTIVE;
        else if (cnt_q == CNT_W'(ENTRY_CYCLES - 1)) state_d = SLP_ASLEEP;
        else cnt_d = cnt_q + 1'b1;
      end
      SLP_ASLEEP: if (!sleep_req_i) begin
        state_d = SLP_RECOVER;
        cnt_d   = '0;
      end
      SLP_RECOVER: begin
        if (sleep_req_i) begin
          state_d = SLP_ENTER;
          cnt_d   = '0;
        end else if (cnt_q == CNT_W'(REC_CYC - 1)) state_d = SLP_ACTIVE;
        else cnt_d = cnt_q + 1'b1;
      end
      default: state_d = SLP_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SLP_ACTIVE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/sleep_seq_filter.sv
module sleep_seq_filter
  import sleep_seq_pkg::*;
(
  input  slp_state_e state_i,
  input  logic       sel_i,
  input  logic       we_i,
  output logic       mem_wr_o,
  output logic       mem_rd_o,
  output logic       in_block_o,
  output logic       wr_block_o
);
  logic full_access;

  assign full_access = (state_i == SLP_ACTIVE) || (state_i == SLP_ENTER);
  assign in_block_o  = (state_i == SLP_ASLEEP);
  assign wr_block_o  = (state_i == SLP_RECOVER);
  assign mem_wr_o    = sel_i && we_i && full_access;
  // recovery admits reads only
  assign mem_rd_o    = sel_i && !we_i && (full_access || wr_block_o);
endmodule

// File: rtl/sleep_seq_store.sv
module sleep_seq_store #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= mem_q[addr_i];
    end
  end
endmodule

// File: rtl/sleep_seq_top.sv
module sleep_seq_top
  import sleep_seq_pkg::*;
#(
  parameter int unsigned ADDR_W        = 4,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_PS = 10000,
  parameter int unsigned RECOVERY_PS   = 20000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_req_i,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_oe_o,
  output logic [1:0]        state_o,
  output logic              in_block_o,
  output logic              wr_block_o
);
  localparam int unsigned REC_RAW = ceil_div(RECOVERY_PS, CLK_PERIOD_PS);
  localparam int unsigned REC_CYC = (REC_RAW == 0) ? 1 : REC_RAW;

  slp_state_e state;
  logic       mem_wr, mem_rd, rvalid;

  sleep_seq_fsm #(.REC_CYC(REC_CYC)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sleep_req_i (sleep_req_i),
    .state_o     (state)
  );

  sleep_seq_filter u_filter (
    .state_i    (state),
    .sel_i      (sel_i),
    .we_i       (we_i),
    .mem_wr_o   (mem_wr),
    .mem_rd_o   (mem_rd),
    .in_block_o (in_block_o),
    .wr_block_o (wr_block_o)
  );

  sleep_seq_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (mem_wr),
    .rd_i     (mem_rd),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid)
  );

  // a read issued on the last entry cycle lands asleep: keep it undriven
  assign rdata_oe_o = rvalid && !in_block_o;
  assign state_o    = state;
endmodule

// File: rtl/sleep_seq_chk.sv
module sleep_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sleep_req_i,
  input logic [1:0] state_i,
  input logic       rdata_oe_i,
  input logic       wr_block_i,
  input logic       mem_wr_i
);
  // R2
  enter_on_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 2'b00 && sleep_req_i) |=> state_i == 2'b01);

  // R2
  no_skip_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 2'b00) |=> (state_i == 2'b00 || state_i == 2'b01));

  // R3
  abort_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 2'b01 && !sleep_req_i) |=> state_i == 2'b00);

  // R5
  asleep_undriven_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 2'b10) |-> !rdata_oe_i);

  // R5
  asleep_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 2'b10) |-> !mem_wr_i);

  // R6
  wake_to_recover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 2'b10 && !sleep_req_i) |=> state_i == 2'b11);

  // R7
  recover_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_block_i |-> !mem_wr_i);

  // R10
  recover_reenter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 2'b11 && sleep_req_i) |=> state_i == 2'b01);
endmodule

bind sleep_seq_top sleep_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sleep_req_i (sleep_req_i),
  .state_i     (state_o),
  .rdata_oe_i  (rdata_oe_o),
  .wr_block_i  (wr_block_o),
  .mem_wr_i    (mem_wr)
);

// File: tb/sleep_seq_top_tb_top.sv
`timescale 1ns/1ps
module sleep_seq_top_tb_top;
  localparam int unsigned AW = 4;
  localparam int unsigned DW = 8;
  localparam int unsigned PER_PS = 10000;
  localparam int unsigned REC_PS = 20000;
  localparam int unsigned REC = ((REC_PS + PER_PS - 1) / PER_PS == 0) ? 1 : (REC_PS + PER_PS - 1) / PER_PS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_req = 1'b0, sel = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rdata_oe, in_block, wr_block;
  logic [1:0] state;

  always #5 clk = ~clk;

  sleep_seq_top #(.ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_PS(PER_PS), .RECOVERY_PS(REC_PS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(sleep_req), .sel_i(sel), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rdata_oe_o(rdata_oe),
    .state_o(state), .in_block_o(in_block), .wr_block_o(wr_block)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  logic [DW-1:0] m_mem [1<<AW];
  logic [1:0]    m_state = 2'b00;
  int            m_cnt = 0;
  logic          m_rv = 1'b0;
  logic [DW-1:0] m_rdata = '0;

  function automatic string tag_of(logic [1:0] s);
    case (s)
      2'b01:   return "R2";
      2'b10:   return "R5";
      2'b11:   return "R6";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [1:0] next_state(logic [1:0] s, int c, logic req);
    case (s)
      2'b00: return req ? 2'b01 : 2'b00;
      2'b01: return !req ? 2'b00 : (c == 1 ? 2'b10 : 2'b01);
      2'b10: return req ? 2'b10 : 2'b11;
      default: return req ? 2'b01 : (c == REC - 1 ? 2'b00 : 2'b11);
    endcase
  endfunction

  task automatic model_edge();
    logic [1:0] ns;
    bit full;
    full = (m_state == 2'b00) || (m_state == 2'b01);
    m_rv = 1'b0;
    if (sel && we && full) m_mem[addr] = wdata;
    if (sel && !we && (full || m_state == 2'b11)) begin
      m_rv = 1'b1;
      m_rdata = m_mem[addr];
    end
    ns = next_state(m_state, m_cnt, sleep_req);
    if (ns != m_state) m_cnt = 0;
    else m_cnt = m_cnt + 1;
    m_state = ns;
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    string t;
    logic  exp_oe;
    t = (tag == "") ? tag_of(m_state) : tag;
    exp_oe = m_rv && (m_state != 2'b10);
    chk(t, "state_o", int'(state), int'(m_state));
    chk(t, "rdata_oe_o", int'(rdata_oe), int'(exp_oe));
    chk(t, "in_block_o", int'(in_block), int'(m_state == 2'b10));
    chk(t, "wr_block_o", int'(wr_block), int'(m_state == 2'b11));
    if (exp_oe) chk(t, "rdata_o", int'(rdata), int'(m_rdata));
  endtask

  task automatic step(logic r, logic s, logic w, logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    sleep_req = r; sel = s; we = w; addr = a; wdata = d;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // fill and read back
    for (int i = 0; i < (1 << AW); i++) step(0, 1, 1, AW'(i), DW'(i * 17 + 3), "R9");
    for (int i = 0; i < 4; i++) step(0, 1, 0, AW'(i), '0, "R9");
    step(0, 0, 0, '0, '0, "R9");

    // entry with traffic during entering
    step(1, 0, 0, '0, '0, "R2");
    step(1, 1, 1, AW'(5), 8'hA5, "R4");
    step(1, 1, 0, AW'(5), '0, "R5");      // read on last entry cycle, masked
    step(1, 1, 1, AW'(3), 8'hFF, "R5");
    step(1, 1, 0, AW'(3), '0, "R5");
    step(1, 1, 0, AW'(3), '0, "R5");
    step(0, 1, 1, AW'(6), 8'h00, "R6");
    step(0, 1, 1, AW'(7), 8'h00, "R7");
    step(0, 1, 0, AW'(5), '0, "R7");
    step(0, 1, 0, AW'(7), '0, "R7");
    for (int i = 0; i < (1 << AW); i++) step(0, 1, 0, AW'(i), '0, "R8");

    // drop during entry
    step(1, 0, 0, '0, '0, "R3");
    step(0, 0, 0, '0, '0, "R3");
    step(1, 0, 0, '0, '0, "R3");
    step(1, 0, 0, '0, '0, "R3");
    step(0, 0, 0, '0, '0, "R3");

    // re-request inside recovery
    step(1, 0, 0, '0, '0, "R10");
    step(1, 0, 0, '0, '0, "R10");
    step(1, 0, 0, '0, '0, "R10");
    step(0, 0, 0, '0, '0, "R10");
    step(1, 0, 0, '0, '0, "R10");
    step(1, 0, 0, '0, '0, "R10");
    step(1, 0, 0, '0, '0, "R10");
    for (int i = 0; i < 4; i++) step(0, 0, 0, '0, '0, "R6");

    // random runs
    for (int n = 0; n < 600; n++) begin
      logic r;
      int   len;
      r   = 1'($urandom % 2);
      len = 1 + int'($urandom % 6);
      for (int k = 0; k < len; k++)
        step(r, 1'($urandom % 4 != 0), 1'($urandom % 2), AW'($urandom), DW'($urandom), "");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule